// File: doc/BRIEF.md
# SPI Flash Passthrough Command Filter

This block sits on the serial path between an upstream SPI host and a downstream serial flash. It forwards every beat of a transaction one clock later. While it does so, it decodes the 8-bit opcode that opens each transaction. The opcode is matched against a bank of command slots. Each slot holds an opcode, a valid flag, an address-length mode, a dummy-beat count, a direction (read or write), a lane width and two substitution enables. A 256-entry filter vector, indexed by opcode value, can veto a command. A vetoed command, or one that has no valid matching slot, reaches the flash as its bare opcode: the downstream select is raised for the rest of the transaction.

For a command that passes, selected address bits and selected bits of the first 32 payload bits can be overwritten with configured values. The block tracks a 3-byte / 4-byte address state from two configurable mode-switch opcodes. For read commands it counts the dummy beats and then enables the upstream return lanes, which carry the flash's read data back to the host.

The block runs on the serial clock. It sees one beat per clock while the upstream select is low. Lanes are modelled as 4-bit buses. Configuration is expected to be static while a transaction is open.

Top module: `spi_pt_filter`

## Requirements
- R1: On reset, `dnCsb` is 1, `upSdoEn` is 0 and `addr4b` is 0.
- R2: During every beat in which `upCsb` is 0, the block registers the upstream lanes and presents them on `dnSdo` one clock later, with `dnCsb` low. The opcode is sent MSB first on lane 0 in beats 0 to 7 and is forwarded unmodified.
- R3: When `cfgFilter[opcode]` is 1, `dnCsb` goes high from the copy of beat 8 onward and stays high until `upCsb` rises. It is high in the clock after any beat with `upCsb` high, and a new transaction is decoded afresh.
- R4: The slot lookup picks the lowest-index slot whose valid flag is 1 and whose opcode is equal to the received opcode. With no such slot, the command is blocked exactly as in R3.
- R5: The address length in beats is set by the slot's 2-bit mode: 0 means no address, 1 means 24, 2 means 32, and 3 means 32 when `addr4b` is 1, else 24. Address bits arrive MSB first on lane 0, starting at beat 8.
- R6: When an opcode completes, `addr4b` becomes 1 if the opcode equals `cfgEn4bOp` and becomes 0 if it equals `cfgEx4bOp`. This happens whether or not the command is filtered or has a slot. An opcode that ends early has no effect.
- R7: With the slot's address-swap flag set, address bit p is forwarded as `cfgAddrVal[p]` wherever `cfgAddrMask[p]` is 1. Otherwise the bit passes unchanged.
- R8: For a write slot (direction 0) with the payload-swap flag set, payload bits 31 down to 0 (the first 32 bits after the address) are replaced by `cfgPayVal` where `cfgPayMask` is 1. The lane width comes from the 2-bit lane code: 1 means dual on lanes 1:0, 2 means quad on lanes 3:0, and any other value means single on lane 0. Within a beat, the higher lane carries the higher bit. Later bits pass unchanged.
- R9: For a read slot (direction 1) that has A address beats and dummy count D (D = 0 means none), `upSdoEn` is 0 up to beat 8+A+D-1. From beat 8+A+D until `upCsb` rises, it equals the lane mask: 0001 for single, 0011 for dual, 1111 for quad. It is 0 for writes and blocked commands.
- R10: `upSdo` equals `dnSdi` on lanes enabled in `upSdoEn` and is 0 on all other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, one beat per rising edge |
| rstN | input | 1 | Active-low reset |
| upCsb | input | 1 | Upstream chip select, active low |
| upSdi | input | 4 | Host-to-device lanes |
| upSdo | output | 4 | Device-to-host lanes |
| upSdoEn | output | 4 | Per-lane drive enable toward the host |
| dnCsb | output | 1 | Downstream chip select, active low |
| dnSdo | output | 4 | Lanes toward the flash |
| dnSdi | input | 4 | Lanes from the flash |
| cfgFilter | input | 256 | Per-opcode block vector |
| cfgSlotOpcode | input | NUM_SLOTS*8 | Slot opcodes |
| cfgSlotValid | input | NUM_SLOTS | Slot valid flags |
| cfgSlotAddrMode | input | NUM_SLOTS*2 | Slot address-length modes |
| cfgSlotDummy | input | NUM_SLOTS*3 | Slot dummy-beat counts |
| cfgSlotRead | input | NUM_SLOTS | Slot direction, 1 = read |
| cfgSlotLanes | input | NUM_SLOTS*2 | Slot lane codes |
| cfgSlotAddrSwap | input | NUM_SLOTS | Slot address substitution enables |
| cfgSlotPaySwap | input | NUM_SLOTS | Slot payload substitution enables |
| cfgAddrMask | input | 32 | Address substitution mask |
| cfgAddrVal | input | 32 | Address substitution values |
| cfgPayMask | input | 32 | Payload substitution mask |
| cfgPayVal | input | 32 | Payload substitution values |
| cfgEn4bOp | input | 8 | Opcode that selects 4-byte addressing |
| cfgEx4bOp | input | 8 | Opcode that selects 3-byte addressing |
| addr4b | output | 1 | Current 4-byte address state |

## Verification
The hardest situations to reach combine state across transactions. One is an address length that follows the tracked 4-byte state after a filtered mode-switch opcode has changed it. Another is an opcode held by two slots, where only the priority rule decides which dummy count applies.

The stimulus sets both up directly. It issues the mode-switch opcodes with filtering on and off, then follows each with a mode-3 read. It gives the fast-read opcode a second, higher-index slot with a different dummy count, so that taking the wrong slot shifts the read-enable beat.

Random transactions then draw opcodes from a list that includes unknown, invalid-slot, filtered and truncated commands, with random lengths and periodically re-randomized masks. Every forwarded beat is compared against a bench model.

// File: rtl/spi_pt_pkg.sv
package spi_pt_pkg;
  localparam int LANES    = 4;
  localparam int OP_BITS  = 8;
  localparam int PAY_BITS = 32;
  localparam int ADDR_MAX = 32;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_DUMMY, ST_WR, ST_RD, ST_BLOCK
  } ptState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       addrPhase;  // substitute address bit on lane 0
    logic [4:0] addrPos;    // address bit index of the current beat
    logic       payPhase;   // substitute payload bits
    logic [5:0] payBase;    // payload bits already consumed
    logic [2:0] laneW;      // active lanes in the payload
    logic       block;      // downstream select forced high
  } ptStrobe_t;
endpackage

// File: rtl/spi_pt_slot_match.sv
module spi_pt_slot_match #(
  parameter int NUM_SLOTS = 24,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [7:0]             opcode,
  input  logic [NUM_SLOTS*8-1:0] slotOpcode,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [NUM_SLOTS-1:0] eq;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign eq[g] = slotValid[g] && (slotOpcode[g*8 +: 8] == opcode);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/spi_pt_ctrl.sv
module spi_pt_ctrl
  import spi_pt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         upCsb,
  input  logic [7:0]   opcodeNow,
  input  logic         hit,
  input  logic [255:0] cfgFilter,
  input  logic [1:0]   slotAddrMode,
  input  logic [2:0]   slotDummy,
  input  logic         slotRead,
  input  logic [1:0]   slotLanes,
  input  logic         slotAddrSwap,
  input  logic         slotPaySwap,
  input  logic [7:0]   cfgEn4bOp,
  input  logic [7:0]   cfgEx4bOp,
  output ptStrobe_t    strb,
  output logic [LANES-1:0] upSdoEn,
  output logic         addr4b
);
  ptState_e   state;
  logic [5:0] cnt;
  logic [5:0] addrBits;
  logic [2:0] dummy;
  logic       isRead;
  logic [1:0] lanes;
  logic       addrSwap;
  logic       paySwap;
  logic [5:0] payCnt;
  logic [5:0] addrBitsNew;
  logic [2:0] laneW;
  logic [LANES-1:0] laneMask;

  function automatic ptState_e afterAddr(input logic rd, input logic [2:0] dm);
    if (!rd) return ST_WR;
    return (dm != 3'd0) ? ST_DUMMY : ST_RD;
  endfunction

  always_comb begin
    case (slotAddrMode)
      2'd1:    addrBitsNew = 6'd24;
      2'd2:    addrBitsNew = 6'd32;
      2'd3:    addrBitsNew = addr4b ? 6'd32 : 6'd24;
      default: addrBitsNew = 6'd0;
    endcase
    case (lanes)
      2'd1:    begin laneW = 3'd2; laneMask = 4'b0011; end
      2'd2:    begin laneW = 3'd4; laneMask = 4'b1111; end
      default: begin laneW = 3'd1; laneMask = 4'b0001; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OP;
      cnt      <= '0;
      addrBits <= '0;
      dummy    <= '0;
      isRead   <= 1'b0;
      lanes    <= '0;
      addrSwap <= 1'b0;
      paySwap  <= 1'b0;
      payCnt   <= '0;
      addr4b   <= 1'b0;
    end else if (upCsb) begin
      state  <= ST_OP;
      cnt    <= '0;
      payCnt <= '0;
    end else begin
      case (state)
        ST_OP: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'(OP_BITS - 1)) begin
            cnt      <= '0;
            addrBits <= addrBitsNew;
            dummy    <= slotDummy;
            isRead   <= slotRead;
            lanes    <= slotLanes;
            addrSwap <= slotAddrSwap;
            paySwap  <= slotPaySwap;
            if (opcodeNow == cfgEn4bOp)      addr4b <= 1'b1;
            else if (opcodeNow == cfgEx4bOp) addr4b <= 1'b0;
            if (!hit || cfgFilter[opcodeNow]) state <= ST_BLOCK;
            else if (addrBitsNew == 6'd0)      state <= afterAddr(slotRead, slotDummy);
            else                               state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          cnt <= cnt + 6'd1;
          if (cnt == addrBits - 6'd1) begin
            cnt   <= '0;
            state <= afterAddr(isRead, dummy);
          end
        end
        ST_DUMMY: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'(dummy) - 6'd1) begin
            cnt   <= '0;
            state <= ST_RD;
          end
        end
        ST_WR: if (payCnt < 6'(PAY_BITS)) payCnt <= payCnt + 6'(laneW);
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.addrPhase = (state == ST_ADDR) && addrSwap;
    strb.addrPos   = 5'(addrBits - 6'd1 - cnt);
    strb.payPhase  = (state == ST_WR) && paySwap && (payCnt < 6'(PAY_BITS));
    strb.payBase   = payCnt;
    strb.laneW     = laneW;
    strb.block     = (state == ST_BLOCK);
    upSdoEn        = (state == ST_RD) ? laneMask : '0;
  end
endmodule

// File: rtl/spi_pt_datapath.sv
module spi_pt_datapath
  import spi_pt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             upCsb,
  input  logic [LANES-1:0] upSdi,
  input  logic [LANES-1:0] dnSdi,
  input  ptStrobe_t        strb,
  input  logic [LANES-1:0] upSdoEn,
  input  logic [31:0]      cfgAddrMask,
  input  logic [31:0]      cfgAddrVal,
  input  logic [31:0]      cfgPayMask,
  input  logic [31:0]      cfgPayVal,
  output logic [7:0]       opcodeNow,
  output logic             dnCsb,
  output logic [LANES-1:0] dnSdo,
  output logic [LANES-1:0] upSdo
);
  logic [6:0]       opShift;
  logic [LANES-1:0] subData;

  assign opcodeNow = {opShift, upSdi[0]};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [4:0] pos;
    logic       usePay;
    logic       payBit;
    assign pos    = 5'(6'd32 - strb.payBase - 6'(strb.laneW) + 6'(l));
    assign usePay = strb.payPhase && (3'(l) < strb.laneW);
    assign payBit = cfgPayMask[pos] ? cfgPayVal[pos] : upSdi[l];
    if (l == 0) begin : g_first
      logic addrBit;
      assign addrBit    = cfgAddrMask[strb.addrPos] ? cfgAddrVal[strb.addrPos] : upSdi[0];
      assign subData[l] = usePay ? payBit : (strb.addrPhase ? addrBit : upSdi[0]);
    end else begin : g_rest
      assign subData[l] = usePay ? payBit : upSdi[l];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opShift <= '0;
      dnCsb   <= 1'b1;
      dnSdo   <= '0;
    end else begin
      if (!upCsb) opShift <= opcodeNow[6:0];
      dnCsb <= upCsb || strb.block;
      dnSdo <= subData;
    end
  end

  assign upSdo = dnSdi & upSdoEn;
endmodule

// File: rtl/spi_pt_filter.sv
module spi_pt_filter
  import spi_pt_pkg::*;
#(
  parameter int NUM_SLOTS = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   upCsb,
  input  logic [3:0]             upSdi,
  output logic [3:0]             upSdo,
  output logic [3:0]             upSdoEn,
  output logic                   dnCsb,
  output logic [3:0]             dnSdo,
  input  logic [3:0]             dnSdi,
  input  logic [255:0]           cfgFilter,
  input  logic [NUM_SLOTS*8-1:0] cfgSlotOpcode,
  input  logic [NUM_SLOTS-1:0]   cfgSlotValid,
  input  logic [NUM_SLOTS*2-1:0] cfgSlotAddrMode,
  input  logic [NUM_SLOTS*3-1:0] cfgSlotDummy,
  input  logic [NUM_SLOTS-1:0]   cfgSlotRead,
  input  logic [NUM_SLOTS*2-1:0] cfgSlotLanes,
  input  logic [NUM_SLOTS-1:0]   cfgSlotAddrSwap,
  input  logic [NUM_SLOTS-1:0]   cfgSlotPaySwap,
  input  logic [31:0]            cfgAddrMask,
  input  logic [31:0]            cfgAddrVal,
  input  logic [31:0]            cfgPayMask,
  input  logic [31:0]            cfgPayVal,
  input  logic [7:0]             cfgEn4bOp,
  input  logic [7:0]             cfgEx4bOp,
  output logic                   addr4b
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  ptStrobe_t  strb;
  logic [7:0] opcodeNow;
  logic       hit;
  logic [IDX_W-1:0] idx;

  spi_pt_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .opcode(opcodeNow), .slotOpcode(cfgSlotOpcode), .slotValid(cfgSlotValid),
    .hit(hit), .idx(idx)
  );

  spi_pt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .upCsb(upCsb), .opcodeNow(opcodeNow), .hit(hit),
    .cfgFilter(cfgFilter),
    .slotAddrMode(cfgSlotAddrMode[idx*2 +: 2]),
    .slotDummy(cfgSlotDummy[idx*3 +: 3]),
    .slotRead(cfgSlotRead[idx]),
    .slotLanes(cfgSlotLanes[idx*2 +: 2]),
    .slotAddrSwap(cfgSlotAddrSwap[idx]),
    .slotPaySwap(cfgSlotPaySwap[idx]),
    .cfgEn4bOp(cfgEn4bOp), .cfgEx4bOp(cfgEx4bOp),
    .strb(strb), .upSdoEn(upSdoEn), .addr4b(addr4b)
  );

  spi_pt_datapath u_dp (
    .clk(clk), .rstN(rstN), .upCsb(upCsb), .upSdi(upSdi), .dnSdi(dnSdi),
    .strb(strb), .upSdoEn(upSdoEn),
    .cfgAddrMask(cfgAddrMask), .cfgAddrVal(cfgAddrVal),
    .cfgPayMask(cfgPayMask), .cfgPayVal(cfgPayVal),
    .opcodeNow(opcodeNow), .dnCsb(dnCsb), .dnSdo(dnSdo), .upSdo(upSdo)
  );
endmodule

// File: rtl/spi_pt_filter_chk.sv
module spi_pt_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       upCsb,
  input logic       dnCsb,
  input logic [3:0] upSdo,
  input logic [3:0] upSdoEn,
  input logic       addr4b
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dnCsb && upSdoEn == 4'h0 && !addr4b));

  // R3
  csb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    upCsb |=> dnCsb);

  // R2
  dn_select_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dnCsb) |-> $past(!upCsb));

  // R9
  lane_mask_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upSdoEn == 4'h0 || upSdoEn == 4'h1 || upSdoEn == 4'h3 || upSdoEn == 4'hF));

  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    upCsb |=> (upSdoEn == 4'h0));

  // R10
  idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((upSdo & ~upSdoEn) == 4'h0));

  // R6
  mode_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addr4b) |-> $past(!upCsb));
endmodule

bind spi_pt_filter spi_pt_filter_chk u_chk (.*);

// File: tb/sim_spi_pt_filter.sv
module sim_spi_pt_filter;
  localparam int NS = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upCsb = 1'b1;
  logic [3:0] upSdi = '0;
  logic [3:0] dnSdi = '0;
  logic [3:0] upSdo, upSdoEn, dnSdo;
  logic dnCsb, addr4b;
  logic [255:0]     cfgFilter = '0;
  logic [NS*8-1:0]  cfgSlotOpcode = '0;
  logic [NS-1:0]    cfgSlotValid = '0;
  logic [NS*2-1:0]  cfgSlotAddrMode = '0;
  logic [NS*3-1:0]  cfgSlotDummy = '0;
  logic [NS-1:0]    cfgSlotRead = '0;
  logic [NS*2-1:0]  cfgSlotLanes = '0;
  logic [NS-1:0]    cfgSlotAddrSwap = '0;
  logic [NS-1:0]    cfgSlotPaySwap = '0;
  logic [31:0] cfgAddrMask = 32'hFF00_00F0, cfgAddrVal = 32'h5A00_0030;
  logic [31:0] cfgPayMask = 32'h0F0F_00C3, cfgPayVal = 32'h0A05_0081;
  logic [7:0]  cfgEn4bOp = 8'hB7, cfgEx4bOp = 8'hE9;

  int checks = 0;
  int errors = 0;
  bit mode4b = 1'b0;

  always #4 clk = ~clk;

  spi_pt_filter #(.NUM_SLOTS(NS)) u0 (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setSlot(input int i, input logic [7:0] op, input bit v, input logic [1:0] am,
                         input logic [2:0] dm, input bit rd, input logic [1:0] ln,
                         input bit aSw, input bit pSw);
    cfgSlotOpcode[i*8 +: 8]  = op;
    cfgSlotValid[i]          = v;
    cfgSlotAddrMode[i*2 +: 2] = am;
    cfgSlotDummy[i*3 +: 3]   = dm;
    cfgSlotRead[i]           = rd;
    cfgSlotLanes[i*2 +: 2]   = ln;
    cfgSlotAddrSwap[i]       = aSw;
    cfgSlotPaySwap[i]        = pSw;
  endtask

  // one upstream transaction of nBeats beats, checked beat by beat
  task automatic txn(input logic [7:0] op, input int nBeats);
    int hitIdx, aLen, dLen, w, pos, base;
    bit blk, rd, aSw, pSw;
    logic [3:0] lm, beat, expOe, prevSdo;
    logic prevCsb;
    string prevTag;
    hitIdx = -1;
    for (int i = NS - 1; i >= 0; i--)
      if (cfgSlotValid[i] && cfgSlotOpcode[i*8 +: 8] == op) hitIdx = i;
    blk = (hitIdx < 0) || cfgFilter[op];
    aLen = 0; dLen = 0; rd = 0; aSw = 0; pSw = 0; w = 1; lm = 4'b0001;
    prevCsb = 1'b1; prevSdo = '0; prevTag = "R2";
    if (hitIdx >= 0) begin
      case (cfgSlotAddrMode[hitIdx*2 +: 2])
        2'd1: aLen = 24;
        2'd2: aLen = 32;
        2'd3: aLen = mode4b ? 32 : 24;
        default: aLen = 0;
      endcase
      dLen = int'(cfgSlotDummy[hitIdx*3 +: 3]);
      rd   = cfgSlotRead[hitIdx];
      aSw  = cfgSlotAddrSwap[hitIdx];
      pSw  = cfgSlotPaySwap[hitIdx];
      case (cfgSlotLanes[hitIdx*2 +: 2])
        2'd1: begin w = 2; lm = 4'b0011; end
        2'd2: begin w = 4; lm = 4'b1111; end
        default: begin w = 1; lm = 4'b0001; end
      endcase
      if (!rd) dLen = 0;
    end
    for (int k = 0; k < nBeats; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(dnCsb == prevCsb, prevTag, $sformatf("dnCsb copy of beat %0d", k - 1),
              32'(dnCsb), 32'(prevCsb));
        check(dnSdo == prevSdo, prevTag, $sformatf("dnSdo copy of beat %0d", k - 1),
              32'(dnSdo), 32'(prevSdo));
      end
      beat = 4'($urandom);
      if (k < 8) beat[0] = op[7 - k];
      upSdi = beat;
      dnSdi = 4'($urandom);
      upCsb = 1'b0;
      expOe = (!blk && rd && k >= 8 + aLen + dLen) ? lm : 4'h0;
      #1;
      check(upSdoEn == expOe, "R9", $sformatf("upSdoEn op %h beat %0d", op, k),
            32'(upSdoEn), 32'(expOe));
      check(upSdo == (dnSdi & expOe), "R10", $sformatf("upSdo beat %0d", k),
            32'(upSdo), 32'(dnSdi & expOe));
      prevSdo = beat; prevCsb = 1'b0; prevTag = "R2";
      if (k >= 8) begin
        if (blk) begin
          prevCsb = 1'b1;
          prevTag = (hitIdx < 0) ? "R4" : "R3";
        end else if (k < 8 + aLen) begin
          pos = aLen - 1 - (k - 8);
          prevTag = "R5/R7";
          if (aSw && cfgAddrMask[pos]) prevSdo[0] = cfgAddrVal[pos];
        end else if (!rd) begin
          base = (k - 8 - aLen) * w;
          prevTag = "R8";
          if (pSw && base < 32)
            for (int l = 0; l < w; l++) begin
              pos = 31 - base - (w - 1 - l);
              if (cfgPayMask[pos]) prevSdo[l] = cfgPayVal[pos];
            end
        end else prevTag = "R9";
      end
    end
    @(negedge clk);
    if (nBeats > 0) begin
      check(dnCsb == prevCsb, prevTag, "dnCsb last beat", 32'(dnCsb), 32'(prevCsb));
      check(dnSdo == prevSdo, prevTag, "dnSdo last beat", 32'(dnSdo), 32'(prevSdo));
    end
    upCsb = 1'b1;
    if (nBeats >= 8) begin
      if (op == cfgEn4bOp) mode4b = 1'b1;
      else if (op == cfgEx4bOp) mode4b = 1'b0;
    end
    @(negedge clk);
    check(dnCsb == 1'b1, "R3", "dnCsb after select release", 32'(dnCsb), 32'd1);
    check(upSdoEn == 4'h0, "R9", "upSdoEn after release", 32'(upSdoEn), 32'd0);
    check(addr4b == mode4b, "R6", $sformatf("addr4b after op %h", op), 32'(addr4b), 32'(mode4b));
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] opList [16];
    void'($urandom(32'd7));
    // slot table: slot1 and slot11 share an opcode so that priority is visible
    setSlot(0,  8'h03, 1, 2'd1, 3'd0, 1, 2'd0, 1, 0);
    setSlot(1,  8'h0B, 1, 2'd3, 3'd7, 1, 2'd0, 1, 0);
    setSlot(2,  8'h3B, 1, 2'd3, 3'd3, 1, 2'd1, 0, 0);
    setSlot(3,  8'h6B, 1, 2'd3, 3'd5, 1, 2'd2, 0, 0);
    setSlot(4,  8'h02, 1, 2'd3, 3'd0, 0, 2'd0, 1, 1);
    setSlot(5,  8'h32, 1, 2'd2, 3'd0, 0, 2'd2, 0, 1);
    setSlot(6,  8'h01, 1, 2'd0, 3'd0, 0, 2'd0, 0, 1);
    setSlot(7,  8'hB7, 1, 2'd0, 3'd0, 0, 2'd0, 0, 0);
    setSlot(8,  8'hE9, 1, 2'd0, 3'd0, 0, 2'd0, 0, 0);
    setSlot(9,  8'h05, 1, 2'd0, 3'd0, 1, 2'd0, 0, 0);
    setSlot(10, 8'hA2, 1, 2'd1, 3'd0, 0, 2'd1, 1, 1);
    setSlot(11, 8'h0B, 1, 2'd1, 3'd3, 1, 2'd2, 0, 0);
    setSlot(12, 8'h20, 0, 2'd1, 3'd0, 0, 2'd0, 0, 0);
    setSlot(13, 8'hC7, 1, 2'd0, 3'd0, 0, 2'd0, 0, 0);
    cfgFilter[8'hC7] = 1'b1;

    repeat (3) @(negedge clk);
    // R1 reset values, held during reset
    check(dnCsb == 1'b1, "R1", "dnCsb in reset", 32'(dnCsb), 32'd1);
    check(upSdoEn == 4'h0, "R1", "upSdoEn in reset", 32'(upSdoEn), 32'd0);
    check(addr4b == 1'b0, "R1", "addr4b in reset", 32'(addr4b), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    txn(8'h03, 8 + 24 + 8);           // R5 3-byte read with address swap
    txn(8'h0B, 8 + 24 + 7 + 6);       // R4 priority: slot1 dummy 7, 3-byte
    txn(8'hB7, 8);                    // R6 enter 4-byte
    txn(8'h0B, 8 + 32 + 7 + 4);       // R5 follows 4-byte state
    txn(8'h03, 8 + 24 + 4);           // R5 fixed 3-byte in 4-byte state
    txn(8'h6B, 8 + 32 + 5 + 3);       // R9 quad read, dummy 5
    txn(8'h3B, 8 + 32 + 3 + 3);       // R9 dual read, dummy 3
    cfgFilter[8'hE9] = 1'b1;
    txn(8'hE9, 12);                   // R6 filtered mode switch still counts
    cfgFilter[8'hE9] = 1'b0;
    txn(8'h3B, 8 + 24 + 3 + 2);       // R5 back to 3-byte
    txn(8'h02, 8 + 24 + 40);          // R8 program with both swaps
    cfgFilter[8'h02] = 1'b1;
    txn(8'h02, 8 + 24 + 8);           // R3 same command filtered
    cfgFilter[8'h02] = 1'b0;
    txn(8'h02, 8 + 24 + 8);           // R3 filter cleared, passes again
    txn(8'h32, 8 + 32 + 12);          // R8 quad payload
    txn(8'hA2, 8 + 24 + 20);          // R8 dual payload
    txn(8'h01, 8 + 40);               // R8 no-address write status
    txn(8'hC7, 20);                   // R3 filtered
    txn(8'h9F, 20);                   // R4 no slot
    txn(8'h20, 20);                   // R4 invalid slot
    txn(8'hB7, 5);                    // R6 truncated opcode has no effect
    txn(8'h05, 8 + 10);               // R9 read with no address and no dummy

    opList = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'h02, 8'h32, 8'h01, 8'hB7,
               8'hE9, 8'h05, 8'hA2, 8'h20, 8'hC7, 8'h9F, 8'hFF, 8'h00};
    for (int t = 0; t < 150; t++) begin
      if (t % 10 == 0) begin
        cfgAddrMask = $urandom; cfgAddrVal = $urandom;
        cfgPayMask  = $urandom; cfgPayVal  = $urandom;
      end
      txn(opList[$urandom % 16], 4 + int'($urandom % 77));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule